// File: doc/BRIEF.md
# Pipeline Hazard Stall and Redirect Controller

This block is the hazard and redirect controller of a five-stage, in-order integer pipeline. In every cycle it looks at three conditions. The first is a load in the execute stage whose destination register is a source of the instruction being decoded. The second is a conditional branch resolving as taken in the memory stage. The third is an arithmetic overflow flagged by the execute stage. From these it produces the write enables for the program counter and the fetch/decode pipeline register, a bubble request for the decode control fields, and three stage flush strobes. It also produces the select for the program counter input multiplexer.

Branches are predicted not taken, so fetch runs ahead sequentially. When the memory stage finds the branch condition true, the three younger instructions are discarded and fetch moves to the branch target. An overflow discards the same instructions and sends fetch to the exception vector 0x4000_0040, which the program counter multiplexer holds as its third input. A load-use hazard freezes fetch and decode for one cycle and sends a bubble down the pipe. A redirect in the same cycle wins over the stall.

All decisions are combinational in the current inputs. A single state bit keeps the pipeline quiet from reset until the first clock edge at which reset is seen released.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `ex_memrd`=1, `ex_dst`≠0 and `ex_dst` equals `id_rs` or `id_rt`, and no redirect is active, the outputs are `pc_we`=0, `ifid_we`=0, `id_bubble`=1, all flushes 0 and `pc_sel`=0.
- R2: A load whose `ex_dst` is register 0 never raises `id_bubble`, even when a source register is also 0.
- R3: With no redirect, a cleared `ex_memrd` or a destination matching neither source gives normal flow: `pc_we`=1, `ifid_we`=1, `id_bubble`=0, all flushes 0, `pc_sel`=0.
- R4: `mem_branch`=1 together with `mem_zero`=1 gives `pc_sel`=1 with `if_flush`, `id_flush` and `ex_flush` all 1, `pc_we`=1, `ifid_we`=1 and `id_bubble`=0.
- R5: `mem_branch` without `mem_zero`, or `mem_zero` without `mem_branch`, is not a taken branch and leaves normal flow.
- R6: `ex_ovf`=1 gives `pc_sel`=2 with all three flushes 1, `pc_we`=1, `ifid_we`=1 and `id_bubble`=0.
- R7: The priority is overflow first, then taken branch, then load-use stall. A redirect cancels a stall in the same cycle, so the bubble is 0 and the PC is written.
- R8: `pc_sel` encodes 0 for the sequential address, 1 for the branch target and 2 for the exception vector. The value 3 never appears.
- R9: While `rst_n` is low, and until the first rising edge at which `rst_n` is sampled high, the outputs are `pc_we`=0, `ifid_we`=0, all three flushes 1, `id_bubble`=0 and `pc_sel`=0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs | input | REG_W | First source register of the instruction in decode |
| id_rt | input | REG_W | Second source register of the instruction in decode |
| ex_memrd | input | 1 | Memory-read control bit of the instruction in execute |
| ex_dst | input | REG_W | Destination register of the instruction in execute |
| mem_branch | input | 1 | Branch control bit of the instruction in the memory stage |
| mem_zero | input | 1 | ALU zero result carried with the memory-stage instruction |
| ex_ovf | input | 1 | ALU overflow from the execute stage |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| id_bubble | output | 1 | Zero the decode control fields entering execute (stall bubble) |
| if_flush | output | 1 | Load a no-op into the fetch/decode register |
| id_flush | output | 1 | Zero the control fields entering the decode/execute register |
| ex_flush | output | 1 | Zero the control fields entering the execute/memory register |
| pc_sel | output | 2 | PC source: 0 sequential, 1 branch target, 2 exception vector |

## Verification
The bench builds the block with the default register-index width of five bits. With that width the comparators are exercised at both ends of the register file: register 0, where a load must never stall, and register 31, the top index. A walked table places every pairing of stall, branch and overflow in the same cycle, so each step of the priority order is seen with the losing request still present. Directed steps then cover the quiet window around reset. This includes the cycle after release and a reset asserted in the middle of a run, where the synchronous reset takes effect only at the following edge.

// File: rtl/hzc_pkg.sv
// Package: shared encodings for the hazard controller.
// Assumes a two-bit PC source select feeding a three-input PC multiplexer.
package hzc_pkg;

    localparam int PCSEL_W = 2;

    // PC multiplexer input choice
    typedef enum logic [PCSEL_W-1:0] {
        PCS_SEQ    = 2'd0,
        PCS_BRANCH = 2'd1,
        PCS_VECTOR = 2'd2
    } pc_src_e;

    // Complete control word produced by the arbiter
    typedef struct packed {
        logic    pc_we;
        logic    ifid_we;
        logic    bubble;
        logic    if_fl;
        logic    id_fl;
        logic    ex_fl;
        pc_src_e sel;
    } hz_ctl_t;

endpackage

// File: rtl/hzc_loaduse.sv
// Load-use detector: compares the execute-stage load destination with every
// source register of the decode-stage instruction.
// Assumes register index 0 is hard-wired and can never carry a dependence.
module hzc_loaduse #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*REG_W-1:0] src_regs,
    input  logic                     ex_memrd,
    input  logic [REG_W-1:0]         ex_dst,
    output logic                     stall_req
);

    logic [NUM_SRC-1:0] hit;

    // One equality comparator per source operand
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        assign hit[g] = (src_regs[g*REG_W +: REG_W] == ex_dst);
    end

    // Stall only for a real load with a writable destination
    always_comb begin
        stall_req = ex_memrd && (ex_dst != '0) && (|hit);
    end

endmodule

// File: rtl/hzc_redirect.sv
// Redirect detector: decides whether this cycle carries an exception redirect
// or a taken-branch redirect, with the exception winning.
// Assumes the branch resolves in the memory stage from its control bit and zero.
module hzc_redirect (
    input  logic run,
    input  logic ex_ovf,
    input  logic mem_branch,
    input  logic mem_zero,
    output logic exc_take,
    output logic br_take
);

    // Exception first, taken branch only when no exception is present
    always_comb begin
        exc_take = run && ex_ovf;
        br_take  = run && mem_branch && mem_zero && !ex_ovf;
    end

endmodule

// File: rtl/hzc_arbiter.sv
// Arbiter: turns the redirect and stall requests into the full control word.
// Assumes at most one of exc_take and br_take is set; a redirect masks a stall.
module hzc_arbiter
    import hzc_pkg::*;
(
    input  logic    run,
    input  logic    exc_take,
    input  logic    br_take,
    input  logic    stall_req,
    output hz_ctl_t ctl
);

    // Priority selection: quiet, exception, branch, stall, normal
    always_comb begin
        ctl = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0,
                if_fl: 1'b0, id_fl: 1'b0, ex_fl: 1'b0, sel: PCS_SEQ};
        if (!run) begin
            ctl.pc_we   = 1'b0;
            ctl.ifid_we = 1'b0;
            ctl.if_fl   = 1'b1;
            ctl.id_fl   = 1'b1;
            ctl.ex_fl   = 1'b1;
        end else if (exc_take) begin
            ctl.if_fl = 1'b1;
            ctl.id_fl = 1'b1;
            ctl.ex_fl = 1'b1;
            ctl.sel   = PCS_VECTOR;
        end else if (br_take) begin
            ctl.if_fl = 1'b1;
            ctl.id_fl = 1'b1;
            ctl.ex_fl = 1'b1;
            ctl.sel   = PCS_BRANCH;
        end else if (stall_req) begin
            ctl.pc_we   = 1'b0;
            ctl.ifid_we = 1'b0;
            ctl.bubble  = 1'b1;
        end
    end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Top of the hazard controller: load-use stall, taken-branch flush and
// overflow redirect for a five-stage in-order pipeline.
// Assumes all inputs are stable stage values for the current cycle; outputs
// are combinational so they act in the same cycle as the condition.
module pipe_hazard_ctrl
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   id_rs,
    input  logic [REG_W-1:0]   id_rt,
    input  logic               ex_memrd,
    input  logic [REG_W-1:0]   ex_dst,
    input  logic               mem_branch,
    input  logic               mem_zero,
    input  logic               ex_ovf,
    output logic               pc_we,
    output logic               ifid_we,
    output logic               id_bubble,
    output logic               if_flush,
    output logic               id_flush,
    output logic               ex_flush,
    output logic [PCSEL_W-1:0] pc_sel
);

    localparam int NUM_SRC = 2;

    logic    run_q;
    logic    stall_req;
    logic    exc_take;
    logic    br_take;
    hz_ctl_t ctl;

    // Run flag: set at the first edge that sees reset released
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    hzc_loaduse #(
        .REG_W   (REG_W),
        .NUM_SRC (NUM_SRC)
    ) u_lu (
        .src_regs  ({id_rt, id_rs}),
        .ex_memrd  (ex_memrd),
        .ex_dst    (ex_dst),
        .stall_req (stall_req)
    );

    hzc_redirect u_rd (
        .run        (run_q),
        .ex_ovf     (ex_ovf),
        .mem_branch (mem_branch),
        .mem_zero   (mem_zero),
        .exc_take   (exc_take),
        .br_take    (br_take)
    );

    hzc_arbiter u_arb (
        .run       (run_q),
        .exc_take  (exc_take),
        .br_take   (br_take),
        .stall_req (stall_req),
        .ctl       (ctl)
    );

    // Unpack the control word onto the ports
    always_comb begin
        pc_we     = ctl.pc_we;
        ifid_we   = ctl.ifid_we;
        id_bubble = ctl.bubble;
        if_flush  = ctl.if_fl;
        id_flush  = ctl.id_fl;
        ex_flush  = ctl.ex_fl;
        pc_sel    = ctl.sel;
    end

endmodule

// File: rtl/hzc_checker.sv
// Checker: temporal properties of the hazard controller, bound to the top.
// Assumes the top's internal run flag is visible as run_q.
module hzc_checker #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_q,
    input logic [REG_W-1:0] ex_dst,
    input logic             mem_branch,
    input logic             mem_zero,
    input logic             ex_ovf,
    input logic             pc_we,
    input logic             ifid_we,
    input logic             id_bubble,
    input logic             if_flush,
    input logic             id_flush,
    input logic             ex_flush,
    input logic [1:0]       pc_sel
);

    // R1: a bubble always freezes PC and IF/ID and keeps sequential select
    a_r1_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        id_bubble |-> (!pc_we && !ifid_we && pc_sel == 2'd0));

    // R2: a load to register 0 never stalls
    a_r2_zero_dst_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> !id_bubble);

    // R4: a taken branch without overflow redirects to the target and flushes
    a_r4_branch_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && mem_branch && mem_zero && !ex_ovf) |->
        (pc_sel == 2'd1 && if_flush && id_flush && ex_flush && pc_we));

    // R6: overflow redirects to the vector and flushes three stages
    a_r6_ovf_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && ex_ovf) |->
        (pc_sel == 2'd2 && if_flush && id_flush && ex_flush && pc_we));

    // R7: a flush never coexists with a stall bubble
    a_r7_flush_cancels_stall: assert property (@(posedge clk) disable iff (!rst_n)
        if_flush |-> !id_bubble);

    // R8: select code 3 is never produced
    a_r8_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel != 2'd3);

    // R9: quiet outputs until the run flag is set
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (!pc_we && !ifid_we && if_flush && id_flush && ex_flush));

    // R9: the run flag only rises after an edge with reset released
    a_r9_run_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> $past(rst_n));

endmodule

bind pipe_hazard_ctrl hzc_checker #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_q      (run_q),
    .ex_dst     (ex_dst),
    .mem_branch (mem_branch),
    .mem_zero   (mem_zero),
    .ex_ovf     (ex_ovf),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .id_bubble  (id_bubble),
    .if_flush   (if_flush),
    .id_flush   (id_flush),
    .ex_flush   (ex_flush),
    .pc_sel     (pc_sel)
);

// File: tb/tb_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_hazard_ctrl;

    // Expected output word: {pc_we, ifid_we, bubble, if_fl, id_fl, ex_fl, sel[1:0]}
    localparam logic [7:0] E_NORM  = 8'b1100_0000;
    localparam logic [7:0] E_STALL = 8'b0010_0000;
    localparam logic [7:0] E_BR    = 8'b1101_1101;
    localparam logic [7:0] E_EXC   = 8'b1101_1110;
    localparam logic [7:0] E_QUIET = 8'b0001_1100;

    typedef struct packed {
        logic [4:0] rs;
        logic [4:0] rt;
        logic       memrd;
        logic [4:0] dst;
        logic       br;
        logic       zr;
        logic       ovf;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{5'd1,  5'd2,  1'b0, 5'd1,  1'b0, 1'b0, 1'b0, E_NORM },  // R3 match, no load
        '{5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 1'b0, 1'b0, E_STALL},  // R1 rs match
        '{5'd3,  5'd7,  1'b1, 5'd7,  1'b0, 1'b0, 1'b0, E_STALL},  // R1 rt match
        '{5'd3,  5'd4,  1'b1, 5'd5,  1'b0, 1'b0, 1'b0, E_NORM },  // R3 load, no match
        '{5'd0,  5'd0,  1'b1, 5'd0,  1'b0, 1'b0, 1'b0, E_NORM },  // R2 load to reg 0
        '{5'd1,  5'd2,  1'b0, 5'd9,  1'b1, 1'b1, 1'b0, E_BR   },  // R4 taken branch
        '{5'd1,  5'd2,  1'b0, 5'd9,  1'b1, 1'b0, 1'b0, E_NORM },  // R5 branch, not zero
        '{5'd1,  5'd2,  1'b0, 5'd9,  1'b0, 1'b1, 1'b0, E_NORM },  // R5 zero, no branch
        '{5'd1,  5'd2,  1'b0, 5'd9,  1'b0, 1'b0, 1'b1, E_EXC  },  // R6 overflow
        '{5'd1,  5'd2,  1'b0, 5'd9,  1'b1, 1'b1, 1'b1, E_EXC  },  // R7 ovf over branch
        '{5'd6,  5'd2,  1'b1, 5'd6,  1'b1, 1'b1, 1'b0, E_BR   },  // R7 branch over stall
        '{5'd6,  5'd2,  1'b1, 5'd6,  1'b0, 1'b0, 1'b1, E_EXC  },  // R7 ovf over stall
        '{5'd31, 5'd0,  1'b1, 5'd31, 1'b0, 1'b0, 1'b0, E_STALL},  // R1 top register
        '{5'd0,  5'd5,  1'b1, 5'd0,  1'b0, 1'b0, 1'b0, E_NORM }   // R2 rs=0, dst=0
    };

    function automatic string tag_of(int i);
        case (i)
            0, 3:        return "R3";
            1, 2, 12:    return "R1";
            4, 13:       return "R2";
            5:           return "R4/R8";
            6, 7:        return "R5";
            8:           return "R6/R8";
            default:     return "R7";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] id_rs, id_rt, ex_dst;
    logic       ex_memrd, mem_branch, mem_zero, ex_ovf;
    logic       pc_we, ifid_we, id_bubble, if_flush, id_flush, ex_flush;
    logic [1:0] pc_sel;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pipe_hazard_ctrl #(.REG_W(5)) dut (
        .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
        .ex_memrd(ex_memrd), .ex_dst(ex_dst), .mem_branch(mem_branch),
        .mem_zero(mem_zero), .ex_ovf(ex_ovf), .pc_we(pc_we),
        .ifid_we(ifid_we), .id_bubble(id_bubble), .if_flush(if_flush),
        .id_flush(id_flush), .ex_flush(ex_flush), .pc_sel(pc_sel)
    );

    task automatic drive(input logic [4:0] rs, input logic [4:0] rt,
                         input logic memrd, input logic [4:0] dst,
                         input logic br, input logic zr, input logic ovf);
        id_rs = rs; id_rt = rt; ex_memrd = memrd; ex_dst = dst;
        mem_branch = br; mem_zero = zr; ex_ovf = ovf;
    endtask

    task automatic expect_word(input logic [7:0] exp, input string tag);
        logic [7:0] act;
        act = {pc_we, ifid_we, id_bubble, if_flush, id_flush, ex_flush, pc_sel};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs actual %b expected %b", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(5'd3, 5'd4, 1'b1, 5'd3, 1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        #1 expect_word(E_QUIET, "R9 in reset, inputs ignored");

        @(negedge clk);
        rst_n = 1'b1;
        #1 expect_word(E_QUIET, "R9 cycle after release");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i].rs, VEC[i].rt, VEC[i].memrd, VEC[i].dst,
                  VEC[i].br, VEC[i].zr, VEC[i].ovf);
            #1 expect_word(VEC[i].exp, tag_of(i));
        end

        // Reset asserted mid-run takes effect at the next edge (R9)
        @(negedge clk);
        rst_n = 1'b0;
        drive(5'd1, 5'd2, 1'b0, 5'd9, 1'b1, 1'b1, 1'b0);
        #1 expect_word(E_BR, "R9 before reset edge");
        @(negedge clk);
        #1 expect_word(E_QUIET, "R9 after reset edge");

        @(negedge clk);
        rst_n = 1'b1;
        drive(5'd8, 5'd8, 1'b1, 5'd8, 1'b0, 1'b0, 1'b0);
        #1 expect_word(E_QUIET, "R9 release window hides stall");
        @(negedge clk);
        #1 expect_word(E_STALL, "R1 stall after restart");
        @(negedge clk);
        drive(5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 1'b0, 1'b0);
        #1 expect_word(E_NORM, "R3 load leaves execute");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule